// File: doc/BRIEF.md
# Virtual-Deadline Speed Scheduler

This block schedules two periodic tasks under fixed rate-monotonic priority and picks a discrete execution speed for whichever task currently holds the processor. Each task is released at the start of its period with a fixed number of work slices. Every slice costs a fixed number of time units at full speed in the worst case. The software running the task reports each finished slice with a one-cycle pulse, and a separate one-cycle pulse marks each elapsed time unit.

For the running task the block works out a virtual deadline. If the high-priority task runs while the low-priority task still has work queued, the high-priority task must finish in its own worst-case time at full speed, so the block forces full speed. If the high-priority task runs alone, its deadline is the end of its own period. If the low-priority task runs, its deadline is the earlier of its own period end and the next release of the high-priority task. From the worst-case time still needed and the virtual deadline, the block selects the slowest speed level that still fits. When neither task has work left, it raises a sleep request that holds until the next period boundary. The periods, slice counts, slice cost and number of speed levels are parameters.

Top module: `vds_sched`

## Requirements
- R1: After reset both tasks are released with full slice counts and both period phases are 0, so the outputs are run_id=0, speed=0 and sleep=0.
- R2: Task 0 has the shorter period and the higher priority. Task 1 runs only when task 0 has no slices left.
- R3: A slice_done pulse lowers the running task's remaining slice count by one. A task whose count reaches zero becomes dormant.
- R4: While task 0 runs and task 1 still has slices left, the speed code is 0 (full speed), whatever time remains.
- R5: While task 0 runs and task 1 is dormant, the virtual deadline is the number of time units left in task 0's period.
- R6: While task 1 runs, the virtual deadline is the smaller of the time left in task 1's period and the time until task 0's next release.
- R7: Let need be the remaining slices times the slice cost. Speed code k (k=0 full, k=1 half, k=2 one third) is the largest k for which need*(k+1) does not exceed the virtual deadline. If no k fits, the code is 0.
- R8: When both tasks are dormant, sleep=1, run_id=0 and speed=0.
- R9: On the tick that ends a task's period, its phase restarts at 0 and its slice count is reloaded to the full value. Any slices left over from the old period are discarded.
- R10: A slice_done pulse while sleep=1 changes no task state.
- R11: If tick ends a period in the same cycle as slice_done for that task, the reload takes effect and the decrement is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse per elapsed time unit |
| slice_done | input | 1 | One-cycle pulse when the running task finishes a slice |
| run_id | output | 1 | Index of the task holding the processor (0 = short period) |
| speed | output | CW | Speed code: 0 full, 1 half, 2 one third |
| sleep | output | 1 | Power-down request; no task has work left |

## Verification
The assertions assume that tick and slice_done are single-cycle pulses and that slice_done arrives only for the task the block reports as running. They also assume the parameters keep task 0's period strictly shorter than task 1's period. The stimulus always drops each pulse after one clock and advances time only by counted ticks. It therefore moves both period phases in lockstep, stays at or below the worst-case slice budget inside every period, and sends slice_done while sleeping only on purpose, to check that it is ignored.

// File: rtl/vds_pkg.sv
package vds_pkg;

    typedef enum logic {
        MODE_DORMANT = 1'b0,
        MODE_ACTIVE  = 1'b1
    } task_mode_e;

    localparam int NUM_TASKS = 2;

endpackage

// File: rtl/vds_task_slot.sv
module vds_task_slot
    import vds_pkg::*;
#(
    parameter int PERIOD = 20,
    parameter int SLICES = 4,
    parameter int TW     = 5,
    parameter int SW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          slice_done,
    output logic [TW-1:0] time_left,
    output logic [SW-1:0] rem,
    output task_mode_e    mode
);

    localparam logic [TW-1:0] LAST_PHASE = TW'(PERIOD - 1);
    localparam logic [TW-1:0] PERIOD_W   = TW'(PERIOD);
    localparam logic [SW-1:0] FULL_LOAD  = SW'(SLICES);

    typedef struct packed {
        logic [TW-1:0] phase;
        logic [SW-1:0] rem;
    } slot_t;

    slot_t slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        if (slice_done && slot_q.rem != '0) begin
            slot_d.rem = slot_q.rem - 1'b1;
        end
        if (tick) begin
            if (slot_q.phase == LAST_PHASE) begin
                slot_d.phase = '0;
                slot_d.rem   = FULL_LOAD;
            end else begin
                slot_d.phase = slot_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q.phase <= '0;
            slot_q.rem   <= FULL_LOAD;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign time_left = PERIOD_W - slot_q.phase;
    assign rem       = slot_q.rem;
    assign mode      = (slot_q.rem != '0) ? MODE_ACTIVE : MODE_DORMANT;

    // R9: phase stays inside the period and the count never exceeds the load
    p_phase_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q.phase <= LAST_PHASE) && (slot_q.rem <= FULL_LOAD));

    // R9, R11: boundary tick reloads regardless of a same-cycle slice_done
    p_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && slot_q.phase == LAST_PHASE) |=> (slot_q.rem == FULL_LOAD && slot_q.phase == '0));

    // R3: a slice_done away from a boundary removes exactly one slice
    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slice_done && !tick && slot_q.rem != '0) |=> (slot_q.rem == $past(slot_q.rem) - 1'b1));

    // R10: with no pulse the count holds
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!slice_done && !tick) |=> $stable(slot_q.rem));

endmodule

// File: rtl/vds_vdeadline.sv
module vds_vdeadline
    import vds_pkg::*;
#(
    parameter int TW   = 5,
    parameter int SW   = 3,
    parameter int COST = 2,
    parameter int WW   = 12
) (
    input  task_mode_e    mode_hi,
    input  task_mode_e    mode_lo,
    input  logic [SW-1:0] rem_hi,
    input  logic [SW-1:0] rem_lo,
    input  logic [TW-1:0] left_hi,
    input  logic [TW-1:0] left_lo,
    output logic          run_id,
    output logic          idle,
    output logic          forced,
    output logic [WW-1:0] need,
    output logic [WW-1:0] vdl
);

    localparam logic [WW-1:0] COST_W = WW'(COST);

    logic [TW-1:0] nearest;

    always_comb begin
        nearest = (left_lo < left_hi) ? left_lo : left_hi;
        run_id  = 1'b0;
        idle    = 1'b0;
        forced  = 1'b0;
        need    = '0;
        vdl     = '0;
        if (mode_hi == MODE_ACTIVE) begin
            need = WW'(rem_hi) * COST_W;
            if (mode_lo == MODE_ACTIVE) begin
                forced = 1'b1;
                vdl    = need;
            end else begin
                vdl = WW'(left_hi);
            end
        end else if (mode_lo == MODE_ACTIVE) begin
            run_id = 1'b1;
            need   = WW'(rem_lo) * COST_W;
            vdl    = WW'(nearest);
        end else begin
            idle = 1'b1;
        end
    end

endmodule

// File: rtl/vds_speed_pick.sv
module vds_speed_pick #(
    parameter int LEVELS = 3,
    parameter int WW     = 12,
    parameter int CW     = 2
) (
    input  logic [WW-1:0] need,
    input  logic [WW-1:0] vdl,
    input  logic          idle,
    input  logic          forced,
    output logic [CW-1:0] code
);

    logic [LEVELS-1:0] fits;

    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        localparam logic [WW-1:0] STRETCH = WW'(k + 1);
        assign fits[k] = (need * STRETCH) <= vdl;
    end

    always_comb begin
        code = '0;
        if (!idle && !forced) begin
            for (int k = 1; k < LEVELS; k++) begin
                if (fits[k]) code = CW'(k);
            end
        end
    end

endmodule

// File: rtl/vds_sched.sv
module vds_sched
    import vds_pkg::*;
#(
    parameter int PERIOD_A = 20,
    parameter int PERIOD_B = 30,
    parameter int SLICES_A = 4,
    parameter int SLICES_B = 6,
    parameter int COST     = 2,
    parameter int LEVELS   = 3,
    localparam int PMAX    = (PERIOD_A > PERIOD_B) ? PERIOD_A : PERIOD_B,
    localparam int SMAX    = (SLICES_A > SLICES_B) ? SLICES_A : SLICES_B,
    localparam int TW      = $clog2(PMAX + 1),
    localparam int SW      = $clog2(SMAX + 1),
    localparam int CW      = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int WW      = TW + SW + $clog2(COST + 1) + $clog2(LEVELS + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          slice_done,
    output logic          run_id,
    output logic [CW-1:0] speed,
    output logic          sleep
);

    localparam int PER [NUM_TASKS] = '{PERIOD_A, PERIOD_B};
    localparam int LOAD[NUM_TASKS] = '{SLICES_A, SLICES_B};

    logic [TW-1:0]  left [NUM_TASKS];
    logic [SW-1:0]  rem  [NUM_TASKS];
    task_mode_e     mode [NUM_TASKS];
    logic           idle, forced;
    logic [WW-1:0]  need, vdl;

    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_task
        logic done_here;
        assign done_here = slice_done && !idle && (run_id == 1'(i));
        vds_task_slot #(
            .PERIOD(PER[i]),
            .SLICES(LOAD[i]),
            .TW    (TW),
            .SW    (SW)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .slice_done(done_here),
            .time_left (left[i]),
            .rem       (rem[i]),
            .mode      (mode[i])
        );
    end

    vds_vdeadline #(
        .TW  (TW),
        .SW  (SW),
        .COST(COST),
        .WW  (WW)
    ) u_vdl (
        .mode_hi(mode[0]),
        .mode_lo(mode[1]),
        .rem_hi (rem[0]),
        .rem_lo (rem[1]),
        .left_hi(left[0]),
        .left_lo(left[1]),
        .run_id (run_id),
        .idle   (idle),
        .forced (forced),
        .need   (need),
        .vdl    (vdl)
    );

    vds_speed_pick #(
        .LEVELS(LEVELS),
        .WW    (WW),
        .CW    (CW)
    ) u_pick (
        .need  (need),
        .vdl   (vdl),
        .idle  (idle),
        .forced(forced),
        .code  (speed)
    );

    assign sleep = idle;

    // R2: the long-period task never runs while the short one has work
    p_priority_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && run_id) |-> (rem[0] == '0));

    // R8: sleep only with both tasks empty, and outputs parked
    p_sleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (rem[0] == '0 && rem[1] == '0 && speed == '0 && run_id == 1'b0));

    // R4: pending low-priority work forces full speed on the high task
    p_forced_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !run_id && rem[1] != '0) |-> (speed == '0));

    // R7: a slowed code always fits the virtual deadline
    p_fit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (speed != '0) |-> ((need * (WW'(speed) + 1'b1)) <= vdl));

    // R10: a slice_done while asleep leaves the sleep state in place
    p_sleep_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !tick) |=> sleep);

endmodule

// File: tb/vds_sched_test.sv
module vds_sched_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       slice_done = 1'b0;
    logic       run_id;
    logic [1:0] speed;
    logic       sleep;

    int n_run  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;   // 8 ns period, 125 MHz

    vds_sched uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .slice_done(slice_done),
        .run_id    (run_id),
        .speed     (speed),
        .sleep     (sleep)
    );

    // {ticks, dones, exp_run, exp_speed, exp_sleep, req}
    localparam int NV = 17;
    localparam logic [31:0] VEC [NV] = '{
        32'h00_00_0_0_0_1,  // R1 reset state
        32'h00_01_0_0_0_4,  // R4 A runs, B pending -> full (R3 count)
        32'h06_03_1_0_0_2,  // R2 A empty, B runs; vdl 14, need 12 -> full
        32'h00_03_1_1_0_7,  // R7 need 6, vdl 14 -> half
        32'h00_01_1_2_0_6,  // R6 need 4, vdl min(24,14) -> third
        32'h00_02_0_0_1_8,  // R8 both empty
        32'h00_01_0_0_1_a,  // R10 slice_done asleep ignored
        32'h0e_00_0_1_0_9,  // R9 A reloaded; R5 vdl 20 need 8 -> half
        32'h00_02_0_2_0_5,  // R5 need 4, vdl 20 -> third
        32'h05_00_0_2_0_5,  // R5 need 4, vdl 15 -> third
        32'h00_02_0_0_1_3,  // R3 A empties -> sleep
        32'h05_00_1_0_0_7,  // R7 B reload, need 12 > vdl 10 -> full
        32'h00_05_1_2_0_6,  // R6 need 2, vdl 10 -> third
        32'h09_00_1_0_0_6,  // R6 vdl min(21,1) -> full
        32'h01_00_0_0_0_2,  // R2 A released preempts B, R4 full
        32'h00_04_1_2_0_6,  // R6 need 2, vdl 20 -> third
        32'h00_01_0_0_1_8   // R8 sleep again
    };

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic pulse_done(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slice_done = 1'b1;
            @(negedge clk) slice_done = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        tick = 1'b0;
        slice_done = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic check(input string req, input logic er, input logic [1:0] es, input logic esl);
        n_run++;
        if (run_id !== er || speed !== es || sleep !== esl) begin
            n_fail++;
            $display("FAIL %s: run_id=%0d speed=%0d sleep=%0d expected run_id=%0d speed=%0d sleep=%0d",
                     req, run_id, speed, sleep, er, es, esl);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        for (int v = 0; v < NV; v++) begin
            pulse_tick(int'(VEC[v][31:24]));
            pulse_done(int'(VEC[v][23:16]));
            check($sformatf("R%0d step %0d", VEC[v][3:0], v),
                  VEC[v][12], VEC[v][9:8], VEC[v][4]);
        end

        // R9: leftover slices discarded; boundary reload restores the full count
        do_reset();
        pulse_done(2);
        pulse_tick(20);
        pulse_done(3);
        check("R9 reload keeps A running", 1'b0, 2'd0, 1'b0);
        pulse_done(1);
        check("R9 A empty after full load", 1'b1, 2'd0, 1'b0);

        // R11: tick at boundary and slice_done in the same cycle
        do_reset();
        pulse_tick(19);
        @(negedge clk) begin tick = 1'b1; slice_done = 1'b1; end
        @(negedge clk) begin tick = 1'b0; slice_done = 1'b0; end
        pulse_done(3);
        check("R11 reload wins over decrement", 1'b0, 2'd0, 1'b0);
        pulse_done(1);
        check("R11 A empties after four slices", 1'b1, 2'd0, 1'b0);

        // R1: reset in the middle of activity restores the release state
        pulse_done(6);
        do_reset();
        check("R1 mid-run reset", 1'b0, 2'd0, 1'b0);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule